// File: doc/BRIEF.md
# ADC Sample and Conversion Sequencer

This block is the digital controller of a successive-approximation analog-to-digital converter. It splits the system clock down to a conversion-clock enable. It runs an acquisition phase that a start request opens. It chooses the event that ends acquisition: software dropping the sample bit, a count of conversion clocks, or a hardware trigger pulse. It then resolves a 12-bit code from a single comparator bit over a fixed 14-period conversion. The finished code goes into a result buffer, together with a one-cycle done flag.

Clearing the enable input aborts a running conversion and leaves the buffer untouched. If that clear lands together with an automatic start, the clear wins. After an abort the sequencer ignores start requests for two conversion-clock periods. The sample-and-hold, the comparator itself and the channel selection sit outside the block. The trial code on `trial` drives the external DAC and comparator.

Top module: `adc_seq`

## Requirements
- R1: `tad_pulse` is a one-cycle enable whose long-run rate is one pulse per (clk_div+1)/2 system cycles; with clk_div = 0 it is high every cycle.
- R2: After reset `sampling`, `converting`, `done` and `result` are all 0.
- R3: While idle with `enable` high, a 0-to-1 change of `sample_bit` starts acquisition; `sampling` is 1 after the next clock edge.
- R4: With trig_sel = 3'b000, a 1-to-0 change of `sample_bit` during acquisition starts conversion; `hw_trig` has no effect in this mode.
- R5: With trig_sel = 3'b111, conversion starts on the max(acq_tads,1)-th `tad_pulse` after acquisition begins (acq_tads = 0 behaves as 1); after each completed conversion acquisition restarts by itself.
- R6: With trig_sel in 3'b001..3'b110, a one-cycle `hw_trig` pulse during acquisition starts conversion.
- R7: A conversion spans 14 `tad_pulse` periods; bits are decided MSB first, one per pulse, keeping a bit when `cmp_in` is 1 for the current `trial`, so `result` equals the largest code with trial <= input.
- R8: `done` is high for exactly one cycle, in the cycle `result` takes its new value; `result` changes at no other time.
- R9: Dropping `enable` during conversion aborts it: `converting` falls, no `done` follows and `result` keeps its previous value.
- R10: If `enable` is low on the same edge that would start an automatic conversion, no conversion starts and the block goes idle.
- R11: After an abort, a `sample_bit` rising edge within the next 2 `tad_pulse` periods is ignored and does not start acquisition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Converter enable; clearing aborts |
| sample_bit | input | 1 | Software sample control bit |
| trig_sel | input | 3 | Conversion trigger source select |
| clk_div | input | 6 | Conversion clock divisor |
| acq_tads | input | 5 | Auto-start acquisition length in conversion clocks |
| hw_trig | input | 1 | Timer or external interrupt trigger pulse |
| cmp_in | input | 1 | Comparator result for the current trial code |
| tad_pulse | output | 1 | Conversion clock enable pulse |
| sampling | output | 1 | Acquisition phase active |
| converting | output | 1 | Conversion phase active |
| trial | output | 12 | Trial code for the external DAC |
| result | output | 12 | Result buffer |
| done | output | 1 | One-cycle conversion complete flag |

## Verification
With clk_div = 1 the conversion clock ticks every cycle. `done` is due on the 15th rising edge after a software or hardware trigger is applied, counting the edge that samples the trigger. In auto-start mode it is due on the (1 + max(acq_tads,1) + 14)-th edge after the start request, and each later result follows 14 + max(acq_tads,1) edges after the one before. The bench drives every stimulus on a falling edge and counts rising edges until it sees `done` at the next falling edge, then compares that count with these figures. Divider rates are counted over windows that are whole multiples of the pulse period, so the phase at the start of the window does not matter. Abort, coincidence and ignored-request cases are observed for several cycles at the ports after the stimulus.

// File: rtl/adc_seq_pkg.sv
// Package: shared widths, trigger codes and the sequencer state type.
// Assumes: a single converter per instance; codes are fixed by the bench.
package adc_seq_pkg;
    localparam int RES_W     = 12;  // result resolution
    localparam int CONV_TADS = 14;  // conversion length in conversion clocks
    localparam int DIV_W     = 6;   // divisor field width
    localparam int ACQ_W     = 5;   // auto-start acquisition count width
    localparam int WAIT_TADS = 2;   // post-abort hold-off in conversion clocks

    localparam logic [2:0] TRIG_SW   = 3'b000;
    localparam logic [2:0] TRIG_AUTO = 3'b111;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SAMPLE  = 2'd1,
        ST_CONVERT = 2'd2,
        ST_HOLD    = 2'd3
    } seq_state_e;
endpackage

// File: rtl/adc_tad_gen.sv
// Conversion clock enable generator. Emits a one-cycle pulse at an average
// rate of 2/(div+1) per system cycle using a fractional accumulator that
// adds 2 each cycle. A divisor of 0 saturates to one pulse per cycle.
// Assumes: div may change at any time; a transient burst of pulses while
// the accumulator drains after a decrease is acceptable.
module adc_tad_gen #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int ACC_W = DIV_W + 1;

    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] limit;
    logic [ACC_W-1:0] sum;

    // Limit and pulse decision for the current accumulator value.
    always_comb begin
        limit = {1'b0, div} + ACC_W'(1);
        sum   = acc + ACC_W'(2);
        tick  = (sum >= limit);
    end

    // Accumulator update: subtract one period on each pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (div == '0) begin
            acc <= '0;
        end else if (tick) begin
            acc <= sum - limit;
        end else begin
            acc <= sum;
        end
    end
endmodule

// File: rtl/adc_sar.sv
// Successive-approximation register. On start it loads the mid-scale trial
// code; on each step it settles one bit MSB first from the comparator and
// sets the next lower bit. Steps beyond RES_W are idle padding; finish is
// raised on the last step of the conversion.
// Assumes: cmp_in reflects the trial code held during the current step.
module adc_sar #(
    parameter int RES_W     = 12,
    parameter int CONV_TADS = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             step_en,
    input  logic             cmp_in,
    output logic [RES_W-1:0] trial,
    output logic             finish
);
    localparam int STEP_W = $clog2(CONV_TADS);
    localparam logic [STEP_W-1:0] LAST = STEP_W'(CONV_TADS - 1);

    logic [STEP_W-1:0] step;
    logic [RES_W-1:0]  nxt;

    // Next trial code: settle the current bit, open the one below.
    always_comb begin
        nxt = trial;
        for (int i = 0; i < RES_W; i++) begin
            if (i == RES_W - 1 - int'(step)) nxt[i] = cmp_in;
            if (i == RES_W - 2 - int'(step)) nxt[i] = 1'b1;
        end
    end

    assign finish = step_en && (step == LAST);

    // Trial register and step counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trial <= '0;
            step  <= '0;
        end else if (start) begin
            trial <= {1'b1, {(RES_W-1){1'b0}}};
            step  <= '0;
        end else if (step_en && (step != LAST)) begin
            trial <= nxt;
            step  <= step + STEP_W'(1);
        end
    end
endmodule

// File: rtl/adc_seq_ctrl.sv
// Sequencer state machine: idle, acquisition, conversion and post-abort
// hold-off. Chooses the conversion trigger from trig_sel, counts auto-start
// acquisition in conversion clocks, writes the result buffer and raises done.
// Assumes: enable low has priority over every trigger in the same cycle.
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int RES_W = 12,
    parameter int ACQ_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             sample_bit,
    input  logic [2:0]       trig_sel,
    input  logic [ACQ_W-1:0] acq_tads,
    input  logic             hw_trig,
    input  logic             tick,
    input  logic             finish,
    input  logic [RES_W-1:0] trial,
    output logic             sar_start,
    output logic             sar_step,
    output logic             sampling,
    output logic             converting,
    output logic [RES_W-1:0] result,
    output logic             done
);
    localparam int CNT_W  = ACQ_W + 1;
    localparam int HOLD_W = $clog2(WAIT_TADS + 1);

    seq_state_e        state;
    logic              samp_q;
    logic [CNT_W-1:0]  acq_cnt;
    logic [CNT_W-1:0]  acq_goal;
    logic [HOLD_W-1:0] hold_cnt;
    logic              rise, fall, fire, auto_mode, complete;

    // Edge detection, trigger selection and sub-block strobes.
    always_comb begin
        rise      = sample_bit && !samp_q;
        fall      = !sample_bit && samp_q;
        auto_mode = (trig_sel == TRIG_AUTO);
        acq_goal  = (acq_tads == '0) ? CNT_W'(1) : {1'b0, acq_tads};
        if (trig_sel == TRIG_SW)  fire = fall;
        else if (auto_mode)       fire = tick && ((acq_cnt + CNT_W'(1)) >= acq_goal);
        else                      fire = hw_trig;
        sar_start  = (state == ST_SAMPLE) && enable && fire;
        sar_step   = (state == ST_CONVERT) && enable && tick;
        complete   = (state == ST_CONVERT) && enable && finish;
        sampling   = (state == ST_SAMPLE);
        converting = (state == ST_CONVERT);
    end

    // Registered copy of the sample bit for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) samp_q <= 1'b0;
        else        samp_q <= sample_bit;
    end

    // Main sequencing state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            acq_cnt  <= '0;
            hold_cnt <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (enable && rise) begin
                        state   <= ST_SAMPLE;
                        acq_cnt <= '0;
                    end
                end
                ST_SAMPLE: begin
                    if (!enable)                  state   <= ST_IDLE;
                    else if (fire)                state   <= ST_CONVERT;
                    else if (auto_mode && tick)   acq_cnt <= acq_cnt + CNT_W'(1);
                end
                ST_CONVERT: begin
                    if (!enable) begin
                        state    <= ST_HOLD;
                        hold_cnt <= '0;
                    end else if (finish) begin
                        state   <= auto_mode ? ST_SAMPLE : ST_IDLE;
                        acq_cnt <= '0;
                    end
                end
                default: begin
                    if (tick) begin
                        if (hold_cnt == HOLD_W'(WAIT_TADS - 1)) state <= ST_IDLE;
                        else hold_cnt <= hold_cnt + HOLD_W'(1);
                    end
                end
            endcase
        end
    end

    // Result buffer and one-cycle done flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            done   <= 1'b0;
        end else begin
            done <= complete;
            if (complete) result <= trial;
        end
    end
endmodule

// File: rtl/adc_seq.sv
// Top of the ADC sequencer: conversion clock generator, control state
// machine and successive-approximation register.
// Assumes: cmp_in is the external comparator decision for the trial output.
module adc_seq
    import adc_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             sample_bit,
    input  logic [2:0]       trig_sel,
    input  logic [DIV_W-1:0] clk_div,
    input  logic [ACQ_W-1:0] acq_tads,
    input  logic             hw_trig,
    input  logic             cmp_in,
    output logic             tad_pulse,
    output logic             sampling,
    output logic             converting,
    output logic [RES_W-1:0] trial,
    output logic [RES_W-1:0] result,
    output logic             done
);
    logic sar_start, sar_step, sar_finish;

    adc_tad_gen #(.DIV_W(DIV_W)) u_tad (
        .clk   (clk),
        .rst_n (rst_n),
        .div   (clk_div),
        .tick  (tad_pulse)
    );

    adc_seq_ctrl #(.RES_W(RES_W), .ACQ_W(ACQ_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .sample_bit (sample_bit),
        .trig_sel   (trig_sel),
        .acq_tads   (acq_tads),
        .hw_trig    (hw_trig),
        .tick       (tad_pulse),
        .finish     (sar_finish),
        .trial      (trial),
        .sar_start  (sar_start),
        .sar_step   (sar_step),
        .sampling   (sampling),
        .converting (converting),
        .result     (result),
        .done       (done)
    );

    adc_sar #(.RES_W(RES_W), .CONV_TADS(CONV_TADS)) u_sar (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (sar_start),
        .step_en (sar_step),
        .cmp_in  (cmp_in),
        .trial   (trial),
        .finish  (sar_finish)
    );
endmodule

// File: rtl/adc_seq_chk.sv
// Assertion checker for adc_seq, attached with bind below.
// Assumes: synchronous active-low reset on rst_n.
module adc_seq_chk #(
    parameter int RES_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             sample_bit,
    input logic [2:0]       trig_sel,
    input logic             sampling,
    input logic             converting,
    input logic [RES_W-1:0] result,
    input logic             done
);
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_result_only_on_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (result != $past(result)) |-> done);

    p_done_after_convert_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(converting));

    p_phase_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(sampling && converting));

    p_abort_no_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (converting && !enable) |=> (!converting && !done));

    p_clear_beats_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sampling && !enable) |=> (!sampling && !converting));

    p_sw_holds_sample_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sampling && enable && trig_sel == 3'b000 && sample_bit) |=> sampling);
endmodule

bind adc_seq adc_seq_chk #(.RES_W(adc_seq_pkg::RES_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .sample_bit (sample_bit),
    .trig_sel   (trig_sel),
    .sampling   (sampling),
    .converting (converting),
    .result     (result),
    .done       (done)
);

// File: tb/tb_adc_seq.sv
// Directed bench for adc_seq; one task per scenario, each checking itself.
module tb_adc_seq;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        sample_bit = 1'b0;
    logic [2:0]  trig_sel = 3'b000;
    logic [5:0]  clk_div = 6'd1;
    logic [4:0]  acq_tads = 5'd1;
    logic        hw_trig = 1'b0;
    logic        cmp_in;
    logic        tad_pulse, sampling, converting, done;
    logic [11:0] trial, result;
    logic [11:0] vin = 12'd0;

    int n_tests = 0;
    int n_fail  = 0;

    assign cmp_in = (trial <= vin);

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_seq dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .sample_bit(sample_bit),
        .trig_sel(trig_sel), .clk_div(clk_div), .acq_tads(acq_tads),
        .hw_trig(hw_trig), .cmp_in(cmp_in), .tad_pulse(tad_pulse),
        .sampling(sampling), .converting(converting), .trial(trial),
        .result(result), .done(done)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Count rising edges until done is seen at a falling edge.
    task automatic wait_done(input int limit, output int n);
        n = 0;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            n++;
            hw_trig = 1'b0;
            if (done) return;
        end
        n = -1;
    endtask

    task automatic go_idle();
        enable = 1'b0; sample_bit = 1'b0; hw_trig = 1'b0;
        cycles(6);
        enable = 1'b1;
        cycles(1);
    endtask

    task automatic t_reset();
        check("R2 sampling", sampling, 0);
        check("R2 converting", converting, 0);
        check("R2 done", done, 0);
        check("R2 result", result, 0);
    endtask

    task automatic t_divider(input int dv, input int win, input int exp);
        int cnt = 0;
        clk_div = 6'(dv);
        cycles(70);
        for (int i = 0; i < win; i++) begin
            @(negedge clk);
            if (tad_pulse) cnt++;
        end
        check($sformatf("R1 pulses div=%0d", dv), cnt, exp);
    endtask

    task automatic t_sw_convert(input int code);
        int n;
        go_idle();
        trig_sel = 3'b000; vin = 12'(code);
        sample_bit = 1'b1;
        cycles(1);
        check("R3 sampling after rise", sampling, 1);
        cycles(3);
        check("R4 still sampling while bit high", sampling, 1);
        sample_bit = 1'b0;
        wait_done(40, n);
        check("R4 sw trigger latency", n, 15);
        check($sformatf("R7 result code %0d", code), result, code);
        cycles(1);
        check("R8 done one cycle", done, 0);
        check("R4 idle after sw conversion", sampling, 0);
    endtask

    task automatic t_sw_ignores_hw();
        int seen = 0;
        go_idle();
        trig_sel = 3'b000; vin = 12'd77;
        sample_bit = 1'b1;
        cycles(2);
        hw_trig = 1'b1;
        cycles(1);
        hw_trig = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (done || converting) seen++;
        end
        check("R4 hw_trig ignored in sw mode", seen, 0);
        check("R4 sampling kept", sampling, 1);
    endtask

    task automatic t_auto(input int acq, input int exp_first);
        int n;
        go_idle();
        trig_sel = 3'b111; acq_tads = 5'(acq); vin = 12'h5A3;
        sample_bit = 1'b1;
        wait_done(60, n);
        check($sformatf("R5 auto first latency acq=%0d", acq), n, exp_first);
        check("R7 auto result", result, 12'h5A3);
        vin = 12'h0F0;
        wait_done(60, n);
        check("R5 auto restart interval", n, exp_first - 1);
        check("R5 auto second result", result, 12'h0F0);
    endtask

    task automatic t_ext();
        int n;
        go_idle();
        trig_sel = 3'b001; vin = 12'hA5C;
        sample_bit = 1'b1;
        cycles(1);
        sample_bit = 1'b0;
        cycles(5);
        check("R6 waiting for hw trigger", sampling, 1);
        hw_trig = 1'b1;
        wait_done(40, n);
        check("R6 hw trigger latency", n, 15);
        check("R6 result", result, 12'hA5C);
    endtask

    task automatic t_abort();
        int bad = 0;
        logic [11:0] old;
        go_idle();
        old = result;
        trig_sel = 3'b001; vin = 12'h123;
        sample_bit = 1'b1;
        cycles(1);
        sample_bit = 1'b0;
        hw_trig = 1'b1;
        cycles(1);
        hw_trig = 1'b0;
        cycles(4);
        check("R9 converting before abort", converting, 1);
        enable = 1'b0;
        cycles(1);
        check("R9 converting after abort", converting, 0);
        enable = 1'b1; sample_bit = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (done || sampling || converting) bad++;
        end
        check("R11 rise during hold-off ignored", bad, 0);
        check("R9 result kept", result, old);
        sample_bit = 1'b0;
        cycles(1);
        sample_bit = 1'b1;
        cycles(1);
        check("R11 start accepted after hold-off", sampling, 1);
    endtask

    task automatic t_coincident();
        int bad = 0;
        go_idle();
        trig_sel = 3'b111; acq_tads = 5'd2;
        sample_bit = 1'b1;
        cycles(2);
        enable = 1'b0;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            if (converting || done || sampling) bad++;
        end
        check("R10 clear beats auto-start", bad, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        cycles(3);
        rst_n = 1'b1;
        cycles(1);
        t_reset();
        t_divider(0, 60, 60);
        t_divider(2, 60, 40);
        t_divider(3, 60, 30);
        t_divider(63, 64, 2);
        t_divider(1, 60, 60);
        t_sw_convert(12'hA5C);
        t_sw_convert(0);
        t_sw_convert(4095);
        t_sw_convert(12'h800);
        t_sw_ignores_hw();
        t_auto(3, 18);
        t_auto(0, 16);
        t_ext();
        t_abort();
        t_coincident();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule